// File: doc/BRIEF.md
# Dual-Word SHA-256 Message Schedule Generator

This block turns one 512-bit padded message block into the 64 schedule words that a SHA-256 compression engine consumes. It delivers the words two at a time, W[2n] and W[2n+1] on each step n, so that it can feed a compression datapath that retires two rounds per clock. A load strobe captures the block and presents the first pair at once. Each advance strobe then moves to the next pair. After 32 steps the whole schedule has been delivered.

Inside, a window of sixteen 32-bit words holds the most recent schedule words, and it shifts by two places per advance. Two copies of the expansion function fill the two vacated slots. The second new word, W[i+17], needs W[i+1] and not W[i+16]. Every operand of either expansion is therefore already held in the window, and no combinational path runs from one new word into the other.

Top module: `sha256_sched2`

## Requirements
- R1: A load strobe sets `active` to 1 and `step` to 0 on the next clock. When `load` and `adv` are high in the same cycle, the load takes effect and the advance is dropped.
- R2: After a load, `w_lo` shows W0 = block[511:480] and `w_hi` shows W1 = block[479:448]. In general, W[k] for k in 0..15 is block[511-32k -: 32], so slices are taken starting from the most significant one.
- R3: For 16 <= i <= 63, W[i] = s1(W[i-2]) + W[i-7] + s0(W[i-15]) + W[i-16] modulo 2^32. Here s0(x) = ror(x,7) ^ ror(x,18) ^ (x >> 3) and s1(x) = ror(x,17) ^ ror(x,19) ^ (x >> 10).
- R4: While `active` is 1 and `step` is n, the outputs are `w_lo` = W[2n] and `w_hi` = W[2n+1]. An advance with `active` high and no load raises `step` by one on the next clock.
- R5: An advance taken at `step` 31 clears `active` and returns `step` to 0 on the next clock, so exactly 64 words are produced for each block.
- R6: An advance while `active` is 0 has no effect. A cycle with neither a load nor a taken advance leaves `active`, `step`, `w_lo` and `w_hi` unchanged.
- R7: A load in the middle of a sequence restarts it at step 0 with the new block's words.
- R8: After reset, `active` is 0 and `step` is 0. Whenever `active` is 0, `step` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Capture `block` and restart at step 0 |
| block | input | 512 | Padded message block, first word in the top bits |
| adv | input | 1 | Move to the next word pair |
| w_lo | output | 32 | Schedule word W[2*step] |
| w_hi | output | 32 | Schedule word W[2*step+1] |
| step | output | 5 | Index of the current word pair |
| active | output | 1 | A block is loaded and words remain |

## Verification
A wrong window slot or a wrong expansion tap leaves W0..W15 correct. It first shows on the outputs at step 8, where W16 and W17 appear, and every pair after that diverges as well. A shift of one place instead of two, or an off-by-one step count, shows up in `step` or in the word pair one cycle after the first advance. The bench compares every pair against an independently computed schedule for three blocks, including mid-sequence reloads and loads that collide with an advance. Each pair is checked in the cycle after the strobe that produced it.

// File: rtl/sha256_sched2.sv
module sha256_sched2 (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [511:0] block,
  input  logic         adv,
  output logic [31:0]  w_lo,
  output logic [31:0]  w_hi,
  output logic [4:0]   step,
  output logic         active
);
  localparam int WORDS = 16;
  localparam int LAST  = 31;

  logic [31:0] win [WORDS];
  logic [31:0] nxt0, nxt1;
  logic        take;

  function automatic logic [31:0] ror(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [31:0] sg0(input logic [31:0] x);
    return ror(x, 7) ^ ror(x, 18) ^ (x >> 3);
  endfunction

  function automatic logic [31:0] sg1(input logic [31:0] x);
    return ror(x, 17) ^ ror(x, 19) ^ (x >> 10);
  endfunction

  assign nxt0 = sg1(win[14]) + win[9]  + sg0(win[1]) + win[0];
  assign nxt1 = sg1(win[15]) + win[10] + sg0(win[2]) + win[1];
  assign take = adv && active && !load;
  assign w_lo = win[0];
  assign w_hi = win[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      step   <= '0;
      for (int k = 0; k < WORDS; k++) win[k] <= '0;
    end else if (load) begin
      active <= 1'b1;
      step   <= '0;
      for (int k = 0; k < WORDS; k++) win[k] <= block[511 - 32*k -: 32];
    end else if (take) begin
      for (int k = 0; k < WORDS - 2; k++) win[k] <= win[k+2];
      win[WORDS-2] <= nxt0;
      win[WORDS-1] <= nxt1;
      if (step == 5'(LAST)) begin
        active <= 1'b0;
        step   <= '0;
      end else begin
        step <= step + 5'd1;
      end
    end
  end
endmodule

module sha256_sched2_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         load,
  input logic [511:0] block,
  input logic         adv,
  input logic [31:0]  w_lo,
  input logic [31:0]  w_hi,
  input logic [4:0]   step,
  input logic         active
);
  p_load_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (active && step == 5'd0));

  p_slice_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (w_lo == $past(block[511:480]) && w_hi == $past(block[479:448])));

  p_step_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && active && !load && step != 5'd31) |=> (active && step == $past(step) + 5'd1));

  p_finish_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && active && !load && step == 5'd31) |=> (!active && step == 5'd0));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(adv && active)) |=> ($stable(step) && $stable(active) && $stable(w_lo) && $stable(w_hi)));

  p_idle_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> step == 5'd0);
endmodule

bind sha256_sched2 sha256_sched2_chk u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .block(block), .adv(adv),
  .w_lo(w_lo), .w_hi(w_hi), .step(step), .active(active)
);

// File: tb/test_sha256_sched2.sv
module test_sha256_sched2;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load = 1'b0;
  logic [511:0] block = '0;
  logic         adv = 1'b0;
  logic [31:0]  w_lo, w_hi;
  logic [4:0]   step;
  logic         active;

  int total = 0;
  int bad = 0;

  sha256_sched2 i_sha256_sched2 (
    .clk(clk), .rst_n(rst_n), .load(load), .block(block), .adv(adv),
    .w_lo(w_lo), .w_hi(w_hi), .step(step), .active(active)
  );

  always #5 clk = ~clk;

  logic [69:0] exp_q [$];
  string       tag_q [$];

  logic [31:0] mw [64];
  logic        m_act = 1'b0;
  int          m_step = 0;

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return {x, x} >> n;
  endfunction

  task automatic build_ref(input logic [511:0] b);
    for (int i = 0; i < 64; i++) begin
      if (i < 16) mw[i] = b[511 - 32*i -: 32];
      else mw[i] = (rr(mw[i-2], 17) ^ rr(mw[i-2], 19) ^ (mw[i-2] >> 10))
                 + mw[i-7]
                 + (rr(mw[i-15], 7) ^ rr(mw[i-15], 18) ^ (mw[i-15] >> 3))
                 + mw[i-16];
    end
  endtask

  task automatic cyc(input logic ld, input logic av, input logic [511:0] b, input string tag);
    @(negedge clk);
    load = ld; adv = av; block = b;
    @(posedge clk);
    #1;
    load = 1'b0; adv = 1'b0;
    if (ld) begin
      build_ref(b);
      m_act = 1'b1; m_step = 0;
    end else if (av && m_act) begin
      if (m_step == 31) begin m_act = 1'b0; m_step = 0; end
      else m_step = m_step + 1;
    end
    exp_q.push_back({m_act, 5'(m_step), mw[2*m_step], mw[2*m_step+1]});
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [69:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (active !== e[69] || step !== e[68:64] ||
          (e[69] && (w_lo !== e[63:32] || w_hi !== e[31:0]))) begin
        bad++;
        $display("FAIL %s: got act=%0b step=%0d lo=%h hi=%h exp act=%0b step=%0d lo=%h hi=%h",
                 t, active, step, w_lo, w_hi, e[69], e[68:64], e[63:32], e[31:0]);
      end
    end
  end

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  logic [511:0] blk_a, blk_b, blk_c;

  initial begin
    blk_a = '0;
    blk_a[511:480] = 32'h61626380;
    blk_a[31:0]    = 32'h00000018;
    for (int k = 0; k < 16; k++) blk_b[511 - 32*k -: 32] = 32'h9e3779b9 * (k + 1) ^ 32'h5a5a0000;
    blk_c = {16{32'hffff0001}};
    for (int k = 0; k < 64; k++) mw[k] = '0;

    repeat (3) @(posedge clk);
    #1;
    total++;
    if (active !== 1'b0 || step !== 5'd0) begin
      bad++;
      $display("FAIL R8: got act=%0b step=%0d exp act=0 step=0", active, step);
    end
    rst_n = 1'b1;

    cyc(1'b0, 1'b1, '0, "R6 idle adv");
    cyc(1'b1, 1'b0, blk_a, "R1 R2 load");
    for (int n = 1; n < 32; n++) cyc(1'b0, 1'b1, '0, "R3 R4 advance");
    cyc(1'b0, 1'b1, '0, "R5 end of block");
    cyc(1'b0, 1'b1, '0, "R6 adv when done");
    cyc(1'b0, 1'b0, '0, "R6 hold idle");

    cyc(1'b1, 1'b0, blk_b, "R2 load B");
    for (int n = 0; n < 10; n++) cyc(1'b0, 1'b1, '0, "R3 advance B");
    cyc(1'b0, 1'b0, '0, "R6 hold mid");
    cyc(1'b1, 1'b0, blk_c, "R7 reload mid");
    cyc(1'b0, 1'b1, '0, "R4 advance C");
    cyc(1'b1, 1'b1, blk_b, "R1 load beats adv");
    for (int n = 1; n < 32; n++) cyc(1'b0, 1'b1, '0, "R3 R4 full B");
    cyc(1'b0, 1'b1, '0, "R5 end B");

    @(negedge clk);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule